// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block places a small direct-mapped data cache between a processor that issues single-word loads and stores and a narrow, slow memory bus that moves one word at a time. Each line carries several 32-bit words, a tag, a valid flag and a dirty flag. Loads and stores that hit finish in the cycle they are presented, with no bus traffic. A store that hits changes only the cached copy and marks the line dirty.

On a miss the controller holds the processor off. If the victim line is dirty, it first copies the line back to memory. It then fetches the missing line one word at a time and lets the held access replay, which now hits. A store miss therefore allocates the line through a normal fetch and merges into it on the replay. Both directions of bus transfer keep to a fixed timing: one address cycle, then for each word 15 idle DRAM cycles followed by one transfer cycle. A four-word transfer takes 65 bus cycles.

The processor keeps its request, address, direction and write data steady until it sees ready high at a rising edge. That edge is the edge at which the access completes.

Top module: `dmc_wb_cache`

## Requirements
- R1: With default parameters the byte address splits into fields as follows. Bits [1:0] select the byte and are ignored, bits [3:2] select the word in the line, bits [6:4] select one of 8 lines, and bits [31:7] form the tag. The line index is the block address (address bits [31:4]) modulo 8. An access hits only when that line is valid and its stored tag equals the address tag.
- R2: Reset, including a reset applied in mid-operation, clears every valid and dirty flag. The first access to any address after reset therefore misses. After reset, with no request, ready is high and the bus is quiet.
- R3: A read hit drives ready high and the addressed word on read data in the same cycle, with zero stall cycles and no bus command.
- R4: A miss on a clean line issues one command cycle with the write flag low and the line-aligned address. It then issues four transfer cycles, each coming exactly 16 cycles after the previous command or transfer. Ready stays low for exactly 66 cycles before the access completes.
- R5: During a fetch, the word delivered on the k-th transfer cycle (k = 0..3) is stored as word k of the line. Later hits on any word of that line return the memory contents of that word.
- R6: A write hit stores the write data in the addressed word with zero stall and no bus command, and marks the line dirty. Memory is not updated.
- R7: A miss on a dirty line first writes the victim back. This takes a command with the write flag high and address {stored tag, index, 4'b0000}, followed by four word transfers in word order. The fetch command comes in the cycle after the last write-back transfer. Ready stays low for exactly 131 cycles.
- R8: A write miss fetches the whole line, then writes the data into the addressed word and marks the line dirty. The other words of the line keep their memory values.
- R9: On a freshly reset cache, block addresses 10110, 11010, 10110, 11010, 10000, 00011, 10000, 10010 give miss, miss, hit, hit, miss, miss, hit, miss.
- R10: Ready is low in every cycle from the cycle a miss is seen until the replayed access completes. A command is issued in the cycle after a miss is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for processor and memory bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while ready is high |
| cpu_ready | output | 1 | Access completes at this edge; low means stall |
| mem_cmd | output | 1 | Bus address cycle |
| mem_wr | output | 1 | Direction of the current bus transfer (1 = write-back) |
| mem_addr | output | 32 | Line-aligned byte address, valid with mem_cmd |
| mem_xfer | output | 1 | One-word transfer cycle |
| mem_wdata | output | 32 | Write-back word, valid with mem_xfer when mem_wr is high |
| mem_rdata | input | 32 | Fetched word, sampled on mem_xfer when mem_wr is low |

## Verification
Several properties assume the processor holds its request, address and direction steady from the cycle a miss is seen until ready returns. The property that expects ready one cycle after a fetch ends depends on exactly that. The assertions also assume that memory supplies a fetched word in the same cycle as the transfer strobe. The stimulus tasks keep to this: they set all request fields at a falling edge, leave them untouched while ready is low, and drop the request only after the completing edge. The bench memory model returns the word for the current transfer combinationally.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_EVICT,
        CS_FILL
    } cache_st_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_ADDR,
        BP_WAIT,
        BP_XFER
    } bus_ph_e;

endpackage

// File: rtl/dmc_bus_seq.sv
module dmc_bus_seq
    import dmc_pkg::*;
#(
    parameter int WOFF_W   = 2,
    parameter int DRAM_LAT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cmd,
    output logic              xfer,
    output logic [WOFF_W-1:0] word,
    output logic              done
);
    localparam int WORDS = 1 << WOFF_W;
    localparam int LAT_W = $clog2(DRAM_LAT + 1);

    typedef struct packed {
        bus_ph_e           ph;
        logic [LAT_W-1:0]  lat;
        logic [WOFF_W-1:0] word;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            BP_IDLE: if (start) s_d.ph = BP_ADDR;
            BP_ADDR: begin
                s_d.ph   = BP_WAIT;
                s_d.lat  = '0;
                s_d.word = '0;
            end
            BP_WAIT: begin
                if (s_q.lat == LAT_W'(DRAM_LAT - 1)) s_d.ph = BP_XFER;
                else                                 s_d.lat = s_q.lat + 1'b1;
            end
            BP_XFER: begin
                if (s_q.word == WOFF_W'(WORDS - 1)) begin
                    s_d.ph = start ? BP_ADDR : BP_IDLE;
                end else begin
                    s_d.word = s_q.word + 1'b1;
                    s_d.lat  = '0;
                    s_d.ph   = BP_WAIT;
                end
            end
            default: s_d.ph = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: BP_IDLE, lat: '0, word: '0};
        else        s_q <= s_d;
    end

    assign cmd  = (s_q.ph == BP_ADDR);
    assign xfer = (s_q.ph == BP_XFER);
    assign word = s_q.word;
    assign done = xfer && (s_q.word == WOFF_W'(WORDS - 1));

    // R4: an address cycle is followed by DRAM wait, never a transfer at once
    p_cmd_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |=> (!cmd && !xfer));

    // R4: transfers inside a line are separated by the DRAM access time
    p_xfer_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !done) |=> !xfer);

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_dty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0]            dty;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } ts_t;

    ts_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (fill_en) begin
            t_d.vld[fill_idx] = 1'b1;
            t_d.dty[fill_idx] = 1'b0;
            t_d.tag[fill_idx] = fill_tag;
        end
        if (mark_en) t_d.dty[mark_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_tag = t_q.tag[rd_idx];
    assign rd_vld = t_q.vld[rd_idx];
    assign rd_dty = t_q.dty[rd_idx];

    // R2: leaving reset, no line is valid
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (t_q.vld == '0));

    // R6: a store hit leaves its line dirty
    p_mark_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en && !fill_en) |=> t_q.dty[$past(mark_idx)]);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 3,
    parameter int WOFF_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << WOFF_W;

    logic [DATA_W-1:0] line_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = line_q[rd_idx][rd_word];

endmodule

// File: rtl/dmc_wb_cache.sv
module dmc_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3,
    parameter int WOFF_W   = 2,
    parameter int DRAM_LAT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_cmd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_xfer,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;

    typedef struct packed {
        cache_st_e        st;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } ctl_t;

    ctl_t r_q, r_d;

    // address fields
    logic [WOFF_W-1:0] a_word;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [BOFF_W-1:0] unused_byte_off;
    assign a_word          = cpu_addr[BOFF_W +: WOFF_W];
    assign a_idx           = cpu_addr[BOFF_W + WOFF_W +: IDX_W];
    assign a_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_byte_off = cpu_addr[BOFF_W-1:0];

    logic              idle;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  st_tag;
    logic              st_vld, st_dty, look_hit;
    logic              seq_start, seq_cmd, seq_xfer, seq_done;
    logic [WOFF_W-1:0] seq_word;
    logic              fill_en, mark_en, dwr_en;
    logic [WOFF_W-1:0] dwr_word;
    logic [DATA_W-1:0] dwr_data, drd_data;

    assign idle     = (r_q.st == CS_IDLE);
    assign look_idx = idle ? a_idx : r_q.idx;
    assign look_hit = st_vld && (st_tag == a_tag);

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_tag   (st_tag),
        .rd_vld   (st_vld),
        .rd_dty   (st_dty),
        .fill_en  (fill_en),
        .fill_idx (r_q.idx),
        .fill_tag (r_q.tag),
        .mark_en  (mark_en),
        .mark_idx (a_idx)
    );

    dmc_data_store #(.IDX_W(IDX_W), .WOFF_W(WOFF_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (look_idx),
        .rd_word (idle ? a_word : seq_word),
        .rd_data (drd_data),
        .wr_en   (dwr_en),
        .wr_idx  (look_idx),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    dmc_bus_seq #(.WOFF_W(WOFF_W), .DRAM_LAT(DRAM_LAT)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .cmd   (seq_cmd),
        .xfer  (seq_xfer),
        .word  (seq_word),
        .done  (seq_done)
    );

    always_comb begin
        r_d       = r_q;
        seq_start = 1'b0;
        fill_en   = 1'b0;
        mark_en   = 1'b0;
        dwr_en    = 1'b0;
        dwr_word  = a_word;
        dwr_data  = cpu_wdata;
        case (r_q.st)
            CS_IDLE: begin
                if (cpu_req) begin
                    if (look_hit) begin
                        if (cpu_we) begin
                            dwr_en  = 1'b1;
                            mark_en = 1'b1;
                        end
                    end else begin
                        r_d.idx   = a_idx;
                        r_d.tag   = a_tag;
                        seq_start = 1'b1;
                        r_d.st    = (st_vld && st_dty) ? CS_EVICT : CS_FILL;
                    end
                end
            end
            CS_EVICT: begin
                if (seq_done) begin
                    seq_start = 1'b1;
                    r_d.st    = CS_FILL;
                end
            end
            CS_FILL: begin
                if (seq_xfer) begin
                    dwr_en   = 1'b1;
                    dwr_word = seq_word;
                    dwr_data = mem_rdata;
                end
                if (seq_done) begin
                    fill_en = 1'b1;
                    r_d.st  = CS_IDLE;
                end
            end
            default: r_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: CS_IDLE, idx: '0, tag: '0};
        else        r_q <= r_d;
    end

    assign cpu_ready = idle && (!cpu_req || look_hit);
    assign cpu_rdata = drd_data;
    assign mem_cmd   = seq_cmd;
    assign mem_xfer  = seq_xfer;
    assign mem_wr    = (r_q.st == CS_EVICT);
    assign mem_wdata = drd_data;
    assign mem_addr  = {(mem_wr ? st_tag : r_q.tag), r_q.idx, {(WOFF_W + BOFF_W){1'b0}}};

    // R10: the processor is stalled whenever the bus is busy
    p_stall_on_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd || mem_xfer) |-> !cpu_ready);

    // R10: a detected miss starts a bus command on the next cycle
    p_miss_starts_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready && idle) |=> mem_cmd);

    // R7: write-back is followed at once by the fetch command
    p_evict_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == CS_EVICT) && seq_done) |=> (mem_cmd && !mem_wr));

    // R4: once the fetch ends, the replayed access completes
    p_fill_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == CS_FILL) && seq_done) |=> cpu_ready);

    // R6: a store hit starts no bus activity
    p_store_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |=> !mem_cmd);

endmodule

// File: tb/dmc_wb_cache_test.sv
module dmc_wb_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLEAN_STALL = 66;
    localparam int DIRTY_STALL = 131;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_cmd, mem_wr, mem_xfer;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmc_wb_cache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_cmd(mem_cmd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_xfer(mem_xfer), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: 256 words, untouched words read as 0xD0000000 | byte address
    logic [31:0] bmem [256];
    logic        bwritten [256];
    logic [7:0]  b_base;
    logic [1:0]  b_cnt;
    logic        b_wr;
    int          cmd_cnt = 0, wrcmd_cnt = 0, xfer_cnt = 0, gap_err = 0, since = 0;
    logic [31:0] last_wr_addr = '0;

    function automatic logic [31:0] init_val(input logic [7:0] widx);
        return 32'hD000_0000 | {22'd0, widx, 2'b00};
    endfunction

    logic [7:0] b_cur;
    assign b_cur     = b_base + {6'd0, b_cnt};
    assign mem_rdata = bwritten[b_cur] ? bmem[b_cur] : init_val(b_cur);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bwritten[i] <= 1'b0;
            b_base <= '0; b_cnt <= '0; b_wr <= 1'b0; since <= 0;
        end else if (mem_cmd) begin
            b_base <= mem_addr[9:2];
            b_cnt  <= '0;
            b_wr   <= mem_wr;
            cmd_cnt <= cmd_cnt + 1;
            if (mem_wr) begin
                wrcmd_cnt    <= wrcmd_cnt + 1;
                last_wr_addr <= mem_addr;
            end
            since <= 1;
        end else if (mem_xfer) begin
            if (since != 16) gap_err <= gap_err + 1;
            since <= 1;
            if (b_wr) begin
                bmem[b_cur]     <= mem_wdata;
                bwritten[b_cur] <= 1'b1;
            end
            b_cnt    <= b_cnt + 1'b1;
            xfer_cnt <= xfer_cnt + 1;
        end else begin
            since <= since + 1;
        end
    end

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [7:0] w;
        w = a[9:2];
        return bwritten[w] ? bmem[w] : init_val(w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int stall);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stall = 0;
        #1;
        while (!cpu_ready) begin
            stall++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R9 table: {5-bit block address, expected hit}
    localparam logic [5:0] SEQ [8] = '{
        {5'b10110, 1'b0}, {5'b11010, 1'b0}, {5'b10110, 1'b1}, {5'b11010, 1'b1},
        {5'b10000, 1'b0}, {5'b00011, 1'b0}, {5'b10000, 1'b1}, {5'b10010, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int st, c0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 ready after reset", {31'd0, cpu_ready}, 32'd1);
        chk("R2 bus quiet after reset", {31'd0, mem_cmd}, 32'd0);

        // R9 / R1: classic sequence, all reads
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            a = {23'd0, SEQ[i][5:1], 4'b0000};
            acc(1'b0, a, '0, rd, st);
            chk($sformatf("R9 stall step %0d", i), st, SEQ[i][0] ? 0 : CLEAN_STALL);
            chk($sformatf("R1 data step %0d", i), rd, init_val(a[9:2]));
        end
        chk("R4 bus gaps", gap_err, 0);
        chk("R4 four words per command", xfer_cnt, 4 * cmd_cnt);
        chk("R4 no write-back on clean misses", wrcmd_cnt, 0);

        // R3 / R5: other words of a filled line hit with memory contents
        c0 = cmd_cnt;
        acc(1'b0, 32'h164, '0, rd, st);
        chk("R3 read hit stall", st, 0);
        chk("R5 word1 data", rd, 32'hD000_0164);
        acc(1'b0, 32'h16C, '0, rd, st);
        chk("R5 word3 data", rd, 32'hD000_016C);
        chk("R3 no bus on hit", cmd_cnt, c0);

        // R6: store hit
        acc(1'b1, 32'h168, 32'h1234_5678, rd, st);
        chk("R6 store hit stall", st, 0);
        chk("R6 no bus on store hit", cmd_cnt, c0);
        chk("R6 memory untouched", mem_word(32'h168), 32'hD000_0168);
        acc(1'b0, 32'h16B, '0, rd, st);
        chk("R6 read back store (R1 byte bits ignored)", rd, 32'h1234_5678);

        // R7: dirty victim at line 6
        w0 = wrcmd_cnt;
        acc(1'b0, 32'h360, '0, rd, st);
        chk("R7 dirty miss stall", st, DIRTY_STALL);
        chk("R7 fetched data", rd, 32'hD000_0360);
        chk("R7 one write-back", wrcmd_cnt, w0 + 1);
        chk("R7 write-back address", last_wr_addr, 32'h160);
        chk("R7 dirty word in memory", mem_word(32'h168), 32'h1234_5678);
        chk("R7 clean word in memory", mem_word(32'h164), 32'hD000_0164);
        chk("R4 bus gaps after write-back", gap_err, 0);
        acc(1'b0, 32'h168, '0, rd, st);
        chk("R7 refetched line clean miss", st, CLEAN_STALL);
        chk("R7 refetched data", rd, 32'h1234_5678);

        // R8: write miss allocates and merges
        acc(1'b1, 32'h3A4, 32'hCAFE_F00D, rd, st);
        chk("R8 write miss stall", st, CLEAN_STALL);
        acc(1'b0, 32'h3A4, '0, rd, st);
        chk("R8 merged word hit", st, 0);
        chk("R8 merged word", rd, 32'hCAFE_F00D);
        acc(1'b0, 32'h3A8, '0, rd, st);
        chk("R8 neighbour word", rd, 32'hD000_03A8);
        acc(1'b0, 32'h124, '0, rd, st);
        chk("R8 line left dirty", st, DIRTY_STALL);
        chk("R8 merged word written back", mem_word(32'h3A4), 32'hCAFE_F00D);

        // R10: ready low across whole miss, checked as continuous stall count
        chk("R10 ready held low", st, DIRTY_STALL);

        // R2: mid-operation reset invalidates
        do_reset();
        #1;
        chk("R2 ready after second reset", {31'd0, cpu_ready}, 32'd1);
        acc(1'b0, 32'h3A4, '0, rd, st);
        chk("R2 miss after reset", st, CLEAN_STALL);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule